// File: doc/BRIEF.md
# Clock Synthesizer Control Register

This block is the 8-bit control register of an on-chip clock synthesizer. It holds the synthesizer enable, the bus clock source select, the loop filter mode (automatic or manual), the bandwidth control bit, the VCO test bit and three plain storage bits. It sits behind a simple write strobe and a combinational read path.

Hardware interlocks tie the enable bit and the source-select bit together. The synthesizer cannot drive the bus clock unless it is already running, and it cannot be switched off while it drives the bus clock. Turning the synthesizer on and switching to it therefore takes two separate writes. A stop or wait request, or a loss of the synthesizer supply, drops the source select back to the reference clock. The register also decodes the enables of the high-bandwidth and low-bandwidth loop filter drivers from the mode bits. In automatic mode it tracks a frequency-near indication to retire the high-bandwidth driver.

Top module: `clk_synth_ctrl`

## Requirements
- R1: While reset is active and just after it, the register reads 0xB8. Bit 7 is enable (1), bit 6 is select (0), bit 5 is auto (1), bit 4 is bandwidth (1), bit 3 is VCO test (1), and bits 2:0 are 000.
- R2: A write with bit 6 set sets select only if the current enable is 1 and write bit 7 is also 1. If select is already 1, a write with bit 6 set keeps it at 1. A write with bit 6 clear clears select.
- R3: A write cannot clear enable while the current select is 1. From the state enable=0, a write with both bits 7 and 6 set sets enable only.
- R4: When stop/wait request or supply-fail is high, select is 0 after the next edge. This takes priority over a same-cycle write.
- R5: VCO test (bit 3) takes write data only when test_mode is 1. Whenever the resulting auto bit is 1, VCO test is forced to 1.
- R6: In manual mode (resulting auto = 0), a write loads bit 4. In auto mode, bit 4 ignores write data.
- R7: In auto mode, freq_near clears bit 4 on the next edge. Otherwise, bit 4 is set when a write raises enable from 0, or when a write enters auto mode from manual. freq_near has priority over both.
- R8: The high-bandwidth driver enable equals bit 4. The low-bandwidth driver enable is 1 in auto mode and equals bit 3 in manual mode.
- R9: Bits 2:0 are plain read/write storage with no side effects.
- R10: rd_data always shows the current register, and auto (bit 5) takes every written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| test_mode | input | 1 | Special test mode; unlocks VCO test bit |
| lp_req | input | 1 | Stop or wait request |
| supply_fail | input | 1 | Synthesizer supply lost |
| freq_near | input | 1 | Synthesizer near target frequency |
| synth_en | output | 1 | Synthesizer enable |
| sel_synth | output | 1 | Bus clock taken from synthesizer |
| hbw_drv_en | output | 1 | High-bandwidth loop filter driver enable |
| lbw_drv_en | output | 1 | Low-bandwidth loop filter driver enable |

## Verification
Any corrupted bit shows on rd_data in the very next cycle after the edge that stores it. Faults in the enable or select bits show at once on synth_en and sel_synth. A wrong filter mode or bandwidth state shows immediately as a wrong hbw_drv_en or lbw_drv_en level. A broken interlock only becomes visible on the write that should have been blocked, so the stimulus repeatedly tries the forbidden combinations from every enable/select state. Clears and freq_near are also driven at the same time as writes.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;
  localparam int unsigned SPARE_W = 3;
  localparam int unsigned REG_W   = 5 + SPARE_W;

  typedef struct packed {
    logic               en;
    logic               sel;
    logic               auto_m;
    logic               bw;
    logic               vcot;
    logic [SPARE_W-1:0] spare;
  } ctl_reg_t;

  localparam ctl_reg_t CTL_RESET = '{en: 1'b1, sel: 1'b0, auto_m: 1'b1,
                                     bw: 1'b1, vcot: 1'b1, spare: '0};
endpackage

// File: rtl/pllctl_interlock.sv
module pllctl_interlock (
  input  logic en_cur,
  input  logic sel_cur,
  input  logic wr,
  input  logic wd_en,
  input  logic wd_sel,
  input  logic clr,
  output logic en_nxt,
  output logic sel_nxt
);
  logic sel_allowed;

  always_comb begin
    // select may only rise when the synthesizer is already on and stays on
    sel_allowed = sel_cur | (en_cur & wd_en);
    en_nxt      = en_cur;
    sel_nxt     = sel_cur;
    if (wr) begin
      en_nxt  = sel_cur | wd_en;
      sel_nxt = wd_sel & sel_allowed;
    end
    if (clr) begin
      sel_nxt = 1'b0;
    end
  end
endmodule

// File: rtl/pllctl_filter.sv
module pllctl_filter (
  input  logic auto_cur,
  input  logic bw_cur,
  input  logic vcot_cur,
  input  logic en_rise,
  input  logic wr,
  input  logic wd_auto,
  input  logic wd_bw,
  input  logic wd_vcot,
  input  logic test_mode,
  input  logic freq_near,
  output logic auto_nxt,
  output logic bw_nxt,
  output logic vcot_nxt
);
  always_comb begin
    auto_nxt = wr ? wd_auto : auto_cur;
    vcot_nxt = vcot_cur;
    bw_nxt   = bw_cur;
    if (wr && test_mode) begin
      vcot_nxt = wd_vcot;
    end
    if (wr && !wd_auto) begin
      bw_nxt = wd_bw;
    end
    if (auto_nxt) begin
      vcot_nxt = 1'b1;
      if (freq_near) begin
        bw_nxt = 1'b0;
      end else if (en_rise || !auto_cur) begin
        bw_nxt = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pllctl_drvdec.sv
module pllctl_drvdec (
  input  logic auto_m,
  input  logic bw,
  input  logic vcot,
  output logic hbw_en,
  output logic lbw_en
);
  always_comb begin
    hbw_en = bw;
    lbw_en = auto_m | vcot;
  end
endmodule

// File: rtl/clk_synth_ctrl.sv
module clk_synth_ctrl
  import pllctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             test_mode,
  input  logic             lp_req,
  input  logic             supply_fail,
  input  logic             freq_near,
  output logic             synth_en,
  output logic             sel_synth,
  output logic             hbw_drv_en,
  output logic             lbw_drv_en
);
  localparam int unsigned SYNC_STAGES = 2;

  ctl_reg_t             wd;
  ctl_reg_t             cur_q;
  ctl_reg_t             nxt_d;
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                 rst_sync_n;
  logic                 en_n, sel_n, auto_n, bw_n, vcot_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  assign wd = ctl_reg_t'(wr_data);

  pllctl_interlock u_lock (
    .en_cur (cur_q.en),
    .sel_cur(cur_q.sel),
    .wr     (wr_en),
    .wd_en  (wd.en),
    .wd_sel (wd.sel),
    .clr    (lp_req | supply_fail),
    .en_nxt (en_n),
    .sel_nxt(sel_n)
  );

  pllctl_filter u_filt (
    .auto_cur (cur_q.auto_m),
    .bw_cur   (cur_q.bw),
    .vcot_cur (cur_q.vcot),
    .en_rise  (en_n & ~cur_q.en),
    .wr       (wr_en),
    .wd_auto  (wd.auto_m),
    .wd_bw    (wd.bw),
    .wd_vcot  (wd.vcot),
    .test_mode(test_mode),
    .freq_near(freq_near),
    .auto_nxt (auto_n),
    .bw_nxt   (bw_n),
    .vcot_nxt (vcot_n)
  );

  always_comb begin
    nxt_d        = cur_q;
    nxt_d.en     = en_n;
    nxt_d.sel    = sel_n;
    nxt_d.auto_m = auto_n;
    nxt_d.bw     = bw_n;
    nxt_d.vcot   = vcot_n;
    if (wr_en) begin
      nxt_d.spare = wd.spare;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cur_q <= CTL_RESET;
    else             cur_q <= nxt_d;
  end

  pllctl_drvdec u_dec (
    .auto_m(cur_q.auto_m),
    .bw    (cur_q.bw),
    .vcot  (cur_q.vcot),
    .hbw_en(hbw_drv_en),
    .lbw_en(lbw_drv_en)
  );

  assign rd_data   = cur_q;
  assign synth_en  = cur_q.en;
  assign sel_synth = cur_q.sel;
endmodule

// File: rtl/pllctl_checker.sv
module pllctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       test_mode,
  input logic       lp_req,
  input logic       supply_fail,
  input logic       freq_near,
  input logic       sel_synth,
  input logic       synth_en,
  input logic       hbw_drv_en,
  input logic       lbw_drv_en
);
  assert_sel_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_synth |-> synth_en);

  assert_no_off_while_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_synth && !lp_req && !supply_fail) |=> synth_en);

  assert_clear_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_req || supply_fail) |=> !sel_synth);

  assert_vcot_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !(wr_en && wr_data[5])) |=> $stable(rd_data[3]));

  assert_auto_vcot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] |-> rd_data[3]);

  assert_near_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] && freq_near && !(wr_en && !wr_data[5])) |=> !hbw_drv_en);

  assert_lbw_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] |-> lbw_drv_en);

  assert_spare_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[2:0]));
endmodule

bind clk_synth_ctrl pllctl_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .test_mode  (test_mode),
  .lp_req     (lp_req),
  .supply_fail(supply_fail),
  .freq_near  (freq_near),
  .sel_synth  (sel_synth),
  .synth_en   (synth_en),
  .hbw_drv_en (hbw_drv_en),
  .lbw_drv_en (lbw_drv_en)
);

// File: tb/clk_synth_ctrl_bench.sv
module clk_synth_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       test_mode = 1'b0, lp_req = 1'b0, supply_fail = 1'b0, freq_near = 1'b0;
  logic [7:0] rd_data;
  logic       synth_en, sel_synth, hbw_drv_en, lbw_drv_en;
  int         n_vec = 0;
  int         n_bad = 0;
  logic [7:0] model;
  bit         finished = 0;

  always #10 clk = ~clk;

  clk_synth_ctrl u_clk_synth_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .test_mode(test_mode), .lp_req(lp_req), .supply_fail(supply_fail),
    .freq_near(freq_near), .synth_en(synth_en), .sel_synth(sel_synth),
    .hbw_drv_en(hbw_drv_en), .lbw_drv_en(lbw_drv_en)
  );

  function automatic logic [7:0] spec_next(logic [7:0] c, logic wr, logic [7:0] d,
                                           logic tm, logic clr, logic fn);
    logic [7:0] n = c;
    if (wr) begin
      n[7]   = c[6] | d[7];
      n[6]   = d[6] & (c[6] | (c[7] & d[7]));
      n[5]   = d[5];
      n[2:0] = d[2:0];
      if (tm)    n[3] = d[3];
      if (!d[5]) n[4] = d[4];
    end
    if (clr) n[6] = 1'b0;
    if (n[5]) begin
      n[3] = 1'b1;
      if (fn) n[4] = 1'b0;
      else if ((n[7] & ~c[7]) | ~c[5]) n[4] = 1'b1;
    end
    return n;
  endfunction

  task automatic fail_line(string req, logic [7:0] act, logic [7:0] exp);
    n_bad++;
    $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
  endtask

  task automatic check_outputs(logic clr_prev);
    n_vec++;
    if (rd_data[7] !== model[7]) fail_line("R3 enable", rd_data, model);
    if (rd_data[6] !== model[6]) fail_line(clr_prev ? "R4 clear" : "R2 select", rd_data, model);
    if (rd_data[5] !== model[5]) fail_line("R10 auto", rd_data, model);
    if (rd_data[4] !== model[4]) fail_line("R6/R7 bandwidth", rd_data, model);
    if (rd_data[3] !== model[3]) fail_line("R5 vco test", rd_data, model);
    if (rd_data[2:0] !== model[2:0]) fail_line("R9 spare", rd_data, model);
    if (synth_en !== model[7] || sel_synth !== model[6])
      fail_line("R10 pins", {6'd0, synth_en, sel_synth}, {6'd0, model[7], model[6]});
    if (hbw_drv_en !== model[4] || lbw_drv_en !== (model[5] | model[3]))
      fail_line("R8 drivers", {6'd0, hbw_drv_en, lbw_drv_en},
                {6'd0, model[4], model[5] | model[3]});
  endtask

  logic last_clr = 1'b0;

  task automatic apply(logic wr, logic [7:0] d, logic tm, logic lp, logic sf, logic fn);
    @(negedge clk);
    check_outputs(last_clr);
    wr_en = wr; wr_data = d; test_mode = tm; lp_req = lp; supply_fail = sf; freq_near = fn;
    last_clr = lp | sf;
    model = spec_next(model, wr, d, tm, lp | sf, fn);
    @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model = 8'hB8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (rd_data !== 8'hB8) fail_line("R1 reset", rd_data, 8'hB8);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (rd_data !== 8'hB8) fail_line("R1 after release", rd_data, 8'hB8);
    // directed corners
    apply(1, 8'h00, 0, 0, 0, 0);  // off, manual (R6)
    apply(1, 8'hC0, 0, 0, 0, 0);  // R3: only enable rises
    apply(1, 8'hC0, 0, 0, 0, 0);  // R2: now select sets
    apply(1, 8'h00, 0, 0, 0, 0);  // R3: enable held, select clears
    apply(1, 8'hC0, 0, 0, 0, 0);
    apply(1, 8'hC0, 0, 1, 0, 0);  // R4: stop/wait beats write
    apply(1, 8'hC0, 0, 0, 0, 0);
    apply(0, 8'h00, 0, 0, 1, 0);  // R4: supply fail
    apply(1, 8'h80, 1, 0, 0, 0);  // R5: test mode clears vco test
    apply(1, 8'h98, 0, 0, 0, 0);  // R5: locked outside test mode
    apply(1, 8'hA5, 0, 0, 0, 0);  // R7: enter auto sets bw; R9 spare
    apply(0, 8'h00, 0, 0, 0, 1);  // R7: freq near clears
    apply(1, 8'h30, 1, 0, 0, 0);  // R6: bw write ignored in auto
    apply(1, 8'h20, 0, 0, 0, 0);  // enable off in auto
    apply(1, 8'hA2, 0, 0, 0, 0);  // R7: enable rise sets bw
    for (int i = 0; i < 3000; i++) begin
      apply($urandom_range(1, 0) == 1, 8'($urandom), $urandom_range(1, 0) == 1,
            $urandom_range(15, 0) == 0, $urandom_range(15, 0) == 0,
            $urandom_range(5, 0) == 0);
    end
    @(negedge clk);
    check_outputs(last_clr);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule